// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block is the bus-side front end of a simple two-stage processor pipeline. While the execution side works on the current instruction, the unit reads the following instruction bytes from memory into a small first-in first-out byte queue. The executor pulls bytes from the head of the queue one at a time. A not-empty flag tells the executor whether a byte is there to take. The unit owns the single memory read/write port. When the executor needs a data access to memory or I/O, it raises a request, and the unit runs that access on the same port.

Data accesses win over prefetch at each bus-cycle boundary. A prefetch cycle already on the bus is never cut short. When the executor performs a control transfer, it pulses a flush input and gives the target address. The queue is emptied, any prefetch in flight is discarded when it completes, and fetching restarts at the target. The fetch address is a plain counter that always names the next byte the unit will read.

Top module: `prefetch_queue_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `q_valid_o`, `mem_req_o` and `dack_o` are low, and `fetch_ptr_o` equals the parameter `RESET_ADDR` (default 0).
- R2: Bytes leave the queue in the order they were fetched. While `q_valid_o` is high, `q_byte_o` shows the oldest byte, and a clock edge with `deq_i` high removes it. The byte fetched from address A is the memory content at A.
- R3: The queue holds `DEPTH` bytes (default 4). A prefetch cycle starts only when fewer than `DEPTH` bytes are queued. With no dequeue, filling stops at `DEPTH` bytes and `mem_req_o` stays low.
- R4: Once `mem_req_o` is high, it stays high with `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stable until an edge at which `mem_ready_i` is high. On the following cycle `mem_req_o` is low.
- R5: Each prefetch cycle drives `mem_addr_o` equal to `fetch_ptr_o`. Each accepted prefetch adds one to `fetch_ptr_o`, wrapping at the address width. After filling from target T the pointer reads T+DEPTH.
- R6: A pending data request starts the next bus cycle. It goes ahead of any prefetch, but a prefetch already on the bus finishes first.
- R7: `dack_o` pulses high for exactly one cycle, the cycle after the edge that completes the data access. For a read (`dwe_i`=0), `drdata_o` then holds the byte at `daddr_i`. For a write (`dwe_i`=1), the bus cycle drives `mem_we_o`=1, `mem_addr_o`=`daddr_i` and `mem_wdata_o`=`dwdata_i`. A `dreq_i` sampled while `dack_o` is high does not start a new access.
- R8: An edge with `flush_i` high empties the queue (`q_valid_o` low on the next cycle) and loads `fetch_ptr_o` with `flush_addr_i`. A `deq_i` on that same edge has no effect. The next bytes delivered come from the target address onward.
- R9: A prefetch cycle that is in flight when a flush occurs completes on the bus. Its byte is dropped, and it does not advance `fetch_ptr_o`.
- R10: `deq_i` while `q_valid_o` is low is ignored. The queue contents and later byte order are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Control transfer: empty queue and redirect fetch |
| flush_addr_i | input | ADDR_W | Transfer target address |
| deq_i | input | 1 | Executor takes the head byte |
| q_valid_o | output | 1 | Queue not empty |
| q_byte_o | output | DATA_W | Head byte of the queue |
| fetch_ptr_o | output | ADDR_W | Address of the next byte to prefetch |
| dreq_i | input | 1 | Executor data access request, held until acknowledged |
| dwe_i | input | 1 | Data access is a write |
| daddr_i | input | ADDR_W | Data access address |
| dwdata_i | input | DATA_W | Data access write byte |
| dack_o | output | 1 | Data access done (one-cycle pulse) |
| drdata_o | output | DATA_W | Data access read byte |
| mem_req_o | output | 1 | Memory bus cycle request |
| mem_we_o | output | 1 | Memory bus cycle is a write |
| mem_addr_o | output | ADDR_W | Memory bus address |
| mem_wdata_o | output | DATA_W | Memory bus write data |
| mem_ready_i | input | 1 | Memory completes the current cycle |
| mem_rdata_i | input | DATA_W | Memory read data |

## Verification
The assertions assume the memory raises `mem_ready_i` only while `mem_req_o` is high, and lowers it the cycle after the completing edge. They also assume the executor holds `dreq_i` and its address and data steady until `dack_o`, then drops the request. The bench's memory responder waits a chosen number of cycles before a single-cycle ready pulse, and it swept latencies 0 to 3 plus longer ones for the flush cases. The executor tasks hold each request until the acknowledge and dequeue only on the cycles they choose. Flush targets include an address near the top of the space so that pointer wrap is exercised.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_FETCH = 2'd1,
    BUS_DATA  = 2'd2
  } bus_st_t;
endpackage

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              not_empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;
  logic              push, pop;

  assign push      = wr_en && !clr;
  assign pop       = rd_en && (cnt != '0) && !clr;
  assign not_empty = (cnt != '0);
  assign full      = (cnt == CAP);
  assign rd_data   = store[rp];

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push) store[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && full && !rd_en));

  p_empty_pop_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cnt == '0 && !wr_en) |=> (cnt == '0));
endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              dreq_i,
  input  logic              dwe_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic [DATA_W-1:0] dwdata_i,
  input  logic              q_full_i,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              dack_o,
  output logic [DATA_W-1:0] drdata_o,
  output logic [ADDR_W-1:0] fetch_ptr_o,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o
);
  bus_st_t st;
  logic    drop;
  logic    data_pend;

  assign data_pend   = dreq_i && !dack_o;
  assign push_o      = (st == BUS_FETCH) && mem_ready_i && !drop && !flush_i;
  assign push_data_o = mem_rdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= BUS_IDLE;
      drop        <= 1'b0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      dack_o      <= 1'b0;
      drdata_o    <= '0;
      fetch_ptr_o <= RESET_ADDR;
    end else begin
      dack_o <= 1'b0;
      if (flush_i) fetch_ptr_o <= flush_addr_i;
      case (st)
        BUS_IDLE: begin
          if (!flush_i) begin
            if (data_pend) begin
              st          <= BUS_DATA;
              mem_req_o   <= 1'b1;
              mem_we_o    <= dwe_i;
              mem_addr_o  <= daddr_i;
              mem_wdata_o <= dwdata_i;
            end else if (!q_full_i) begin
              st          <= BUS_FETCH;
              drop        <= 1'b0;
              mem_req_o   <= 1'b1;
              mem_we_o    <= 1'b0;
              mem_addr_o  <= fetch_ptr_o;
            end
          end
        end
        BUS_FETCH: begin
          if (flush_i) drop <= 1'b1;
          if (mem_ready_i) begin
            st        <= BUS_IDLE;
            mem_req_o <= 1'b0;
            if (!drop && !flush_i) fetch_ptr_o <= fetch_ptr_o + 1'b1;
          end
        end
        BUS_DATA: begin
          if (mem_ready_i) begin
            st        <= BUS_IDLE;
            mem_req_o <= 1'b0;
            mem_we_o  <= 1'b0;
            dack_o    <= 1'b1;
            if (!mem_we_o) drdata_o <= mem_rdata_i;
          end
        end
        default: st <= BUS_IDLE;
      endcase
    end
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  p_req_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_ready_i) |=> !mem_req_o);

  p_slot_needed_r3: assert property (@(posedge clk) disable iff (rst)
    (st == BUS_IDLE && !flush_i && !data_pend && q_full_i) |=> !mem_req_o);

  p_data_first_r6: assert property (@(posedge clk) disable iff (rst)
    (st == BUS_IDLE && !flush_i && data_pend) |=> (mem_req_o && st == BUS_DATA));

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (st == BUS_DATA && mem_ready_i) |=> (dack_o ##1 !dack_o));

  p_ptr_load_r8: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (fetch_ptr_o == $past(flush_addr_i)));

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
    !flush_i |=> (fetch_ptr_o == $past(fetch_ptr_o) ||
                  fetch_ptr_o == ADDR_W'($past(fetch_ptr_o) + 1'b1)));

  p_drop_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (drop && st == BUS_FETCH && mem_ready_i && !flush_i) |=> $stable(fetch_ptr_o));
endmodule

// File: rtl/prefetch_queue_unit.sv
module prefetch_queue_unit #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              deq_i,
  output logic              q_valid_o,
  output logic [DATA_W-1:0] q_byte_o,
  output logic [ADDR_W-1:0] fetch_ptr_o,
  input  logic              dreq_i,
  input  logic              dwe_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic [DATA_W-1:0] dwdata_i,
  output logic              dack_o,
  output logic [DATA_W-1:0] drdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              q_full;
  logic              push;
  logic [DATA_W-1:0] push_data;

  pfq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_ADDR(RESET_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .dreq_i(dreq_i), .dwe_i(dwe_i), .daddr_i(daddr_i), .dwdata_i(dwdata_i),
    .q_full_i(q_full),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .dack_o(dack_o), .drdata_o(drdata_o),
    .fetch_ptr_o(fetch_ptr_o),
    .push_o(push), .push_data_o(push_data)
  );

  pfq_fifo #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_fifo (
    .clk(clk), .rst(rst), .clr(flush_i),
    .wr_en(push), .wr_data(push_data),
    .rd_en(deq_i), .rd_data(q_byte_o),
    .not_empty(q_valid_o), .full(q_full)
  );

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !q_valid_o);
endmodule

// File: tb/tb_prefetch_queue_unit.sv
module tb_prefetch_queue_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        flush_i = 1'b0;
  logic [15:0] flush_addr_i = '0;
  logic        deq_i = 1'b0;
  logic        q_valid_o;
  logic [7:0]  q_byte_o;
  logic [15:0] fetch_ptr_o;
  logic        dreq_i = 1'b0, dwe_i = 1'b0;
  logic [15:0] daddr_i = '0;
  logic [7:0]  dwdata_i = '0;
  logic        dack_o;
  logic [7:0]  drdata_o;
  logic        mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_ready_i;
  logic [7:0]  mem_rdata_i;

  int total = 0, bad = 0;
  int lat = 0;
  int n_starts = 0;
  logic [15:0] start_addr;
  logic        start_we;
  logic        wr_seen = 1'b0;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;

  always #5 clk = ~clk;

  prefetch_queue_unit dut (
    .clk(clk), .rst(rst), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .deq_i(deq_i), .q_valid_o(q_valid_o), .q_byte_o(q_byte_o),
    .fetch_ptr_o(fetch_ptr_o), .dreq_i(dreq_i), .dwe_i(dwe_i),
    .daddr_i(daddr_i), .dwdata_i(dwdata_i), .dack_o(dack_o),
    .drdata_o(drdata_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [7:0] mval(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ (a[15:8] + 8'd3);
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  // memory responder: ready after lat waiting cycles, one-cycle pulse
  initial begin : responder
    int w = 0;
    logic prev_req = 1'b0;
    logic [15:0] held = '0;
    mem_ready_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      if (mem_ready_i) begin
        mem_ready_i = 1'b0;
        w = 0;
        chk(!mem_req_o, "R4 gap", mem_req_o, 0);
      end else if (mem_req_o) begin
        if (!prev_req) begin
          n_starts++;
          start_addr = mem_addr_o;
          start_we = mem_we_o;
          held = mem_addr_o;
        end else begin
          chk(mem_addr_o == held, "R4 hold", mem_addr_o, held);
        end
        if (w >= lat) begin
          mem_ready_i = 1'b1;
          mem_rdata_i = mval(mem_addr_o);
          if (mem_we_o) begin
            wr_seen = 1'b1;
            wr_addr = mem_addr_o;
            wr_data = mem_wdata_o;
          end
        end else w++;
      end
      prev_req = mem_req_o;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic flush_to(input logic [15:0] t, input bit with_deq);
    step();
    flush_i = 1'b1;
    flush_addr_i = t;
    deq_i = with_deq;
    step();
    flush_i = 1'b0;
    deq_i = 1'b0;
    chk(!q_valid_o, "R8 empty", q_valid_o, 0);
    chk(fetch_ptr_o == t, "R8 ptr", fetch_ptr_o, t);
  endtask

  task automatic consume(input logic [15:0] s, input int n, input string rq);
    int got = 0;
    int guard = 0;
    while (got < n && guard < 400) begin
      step();
      deq_i = 1'b0;
      if (q_valid_o) begin
        chk(q_byte_o == mval(16'(s + got)), rq, q_byte_o, mval(16'(s + got)));
        deq_i = 1'b1;
        got++;
      end
      guard++;
    end
    step();
    deq_i = 1'b0;
    chk(got == n, rq, got, n);
  endtask

  task automatic data_access(input bit we, input logic [15:0] a, input logic [7:0] d);
    int s0;
    int guard = 0;
    bit seen = 1'b0;
    step();
    dreq_i = 1'b1; dwe_i = we; daddr_i = a; dwdata_i = d;
    wr_seen = 1'b0;
    s0 = n_starts;
    while (!dack_o && guard < 200) begin
      step();
      if (!seen && n_starts > s0) begin
        seen = 1'b1;
        chk(start_addr == a && start_we == we, "R6 first cycle", start_addr, a);
      end
      guard++;
    end
    chk(dack_o, "R7 ack", dack_o, 1);
    if (we) begin
      chk(wr_seen && wr_addr == a && wr_data == d, "R7 write", wr_data, d);
    end else begin
      chk(drdata_o == mval(a), "R7 read", drdata_o, mval(a));
    end
    dreq_i = 1'b0;
    step();
    chk(!dack_o, "R7 pulse", dack_o, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] tg [4];
    tg[0] = 16'h0000; tg[1] = 16'h00FE; tg[2] = 16'hFFFE; tg[3] = 16'h1234;
    rst = 1'b1;
    repeat (3) step();
    // R1 reset state
    chk(!q_valid_o && !mem_req_o && !dack_o, "R1 outputs", {q_valid_o, mem_req_o, dack_o}, 0);
    chk(fetch_ptr_o == 16'h0000, "R1 ptr", fetch_ptr_o, 0);
    rst = 1'b0;
    step();
    chk(!q_valid_o && !dack_o, "R1 after", q_valid_o, 0);

    // R2 R3 R5 sweep of latency and targets
    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int k = 0; k < 4; k++) begin
        flush_to(tg[k], 1'b0);
        repeat (40) step();
        chk(fetch_ptr_o == 16'(tg[k] + 4), "R5 ptr after fill", fetch_ptr_o, 16'(tg[k] + 4));
        chk(q_valid_o, "R3 filled", q_valid_o, 1);
        for (int c = 0; c < 4; c++) begin
          step();
          chk(!mem_req_o, "R3 no fetch when full", mem_req_o, 0);
        end
        consume(tg[k], 8, "R2 order");
      end
    end

    // R8 flush with dequeue on the same edge
    lat = 1;
    flush_to(16'h0500, 1'b0);
    repeat (30) step();
    flush_to(16'h0A00, 1'b1);
    consume(16'h0A00, 5, "R8 restart");

    // R9 flush while prefetch in flight
    lat = 5;
    flush_to(16'h2000, 1'b0);
    step(); step();
    chk(mem_req_o, "R9 in flight", mem_req_o, 1);
    flush_to(16'h3000, 1'b0);
    step(); step();
    chk(fetch_ptr_o == 16'h3000, "R9 ptr held", fetch_ptr_o, 16'h3000);
    consume(16'h3000, 6, "R9 dropped byte");

    // R10 dequeue on empty queue
    lat = 6;
    flush_to(16'h4000, 1'b0);
    chk(!q_valid_o, "R10 empty", q_valid_o, 0);
    deq_i = 1'b1;
    step();
    deq_i = 1'b0;
    chk(!q_valid_o, "R10 still empty", q_valid_o, 0);
    consume(16'h4000, 4, "R10 order kept");

    // R6 R7 data access priority and completion
    lat = 3;
    flush_to(16'h5000, 1'b0);
    step();
    data_access(1'b0, 16'h7123, 8'h00);
    data_access(1'b1, 16'h7200, 8'hA5);
    lat = 0;
    data_access(1'b0, 16'hBEEF, 8'h00);
    consume(16'h5000, 6, "R6 queue intact");
    repeat (20) step();
    data_access(1'b1, 16'h0042, 8'h3C);
    consume(16'h5006, 4, "R6 after data");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule